// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Row Tracker

This block is the device-side front end of a four-bank synchronous DRAM organised as 4096 rows by 512 columns by 8 bits. On every rising clock edge it samples the clock enable, the active-low command strobes, the address bus and a two-bit bank number. From these it decodes a command and keeps, for each bank, an open flag and the row that bank holds. It reports each accepted command as a one-cycle strobe with its bank, row and column fields.

The block also produces per-beat data-path controls from the data mask. While the last accepted column command was a read, the output driver is enabled only when the mask is low. While it was a write, the array write strobe is raised only when the mask is low, so a masked byte keeps its old contents. A read to a closed bank, a write to a closed bank, or an activate to an open bank is refused and reported as an illegal command.

A low clock enable makes the following edge void, which gives power-down and clock suspend. On that edge all state and all outputs hold.

Top module: `sdram_cmd_front`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} with activate 0011, read 0101, write 0100 and precharge 0010. Every other pattern, and every refused command, is treated as no operation. One edge after an accepted command, `cmd_vld` is 1 and `cmd_code` shows 1 for activate, 2 for read, 3 for write and 4 for precharge. Otherwise both are 0.
- R2: If `cke` was low at the previous rising edge, the current edge is void. Bank state, the data-path enables and every decoded output keep their values.
- R3: While `cs_n` is high, no command is taken. Bank state is unchanged and `cmd_vld` is 0.
- R4: An activate to a closed bank stores `addr[11:0]` as that bank's row and sets its bit in `bank_open`. `cmd_row` then shows the stored row.
- R5: An accepted read or write reports `cmd_col = addr[8:0]` as the burst start column. It also reports `cmd_row` as the row open in the target bank.
- R6: A precharge with `addr[10]` high closes all four banks and raises `prech_all` for that cycle.
- R7: A precharge with `addr[10]` low closes only the bank named by `bsel`. The other banks keep their state.
- R8: `bsel` is the bank number, with `bsel[0]` carrying A12 (LSB) and `bsel[1]` carrying A13 (MSB). `bank_open[n]` and `cmd_bank` refer to that number.
- R9: After an accepted read, and until the next read, write or precharge, `rd_oe` equals the inverse of `dqm` sampled on the same edge. In that state `wr_en` is 0.
- R10: After an accepted write, and until the next read, write or precharge, `wr_en` equals the inverse of `dqm` sampled on the same edge. In that state `rd_oe` is 0. A precharge sets both to 0.
- R11: A read or write to a closed bank, or an activate to an open bank, raises `illegal` for one cycle. The command is not accepted and the bank state is unchanged.
- R12: A synchronous reset (`rst_n` low at an edge) closes all banks, clears the stored rows and sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low voids the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Row address, column address in bits 8:0, precharge scope in bit 10 |
| bsel | input | 2 | Bank number (bit 0 = A12, bit 1 = A13) |
| dqm | input | 1 | Data mask for the current beat |
| cmd_vld | output | 1 | An accepted command was decoded |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the last accepted command |
| cmd_row | output | 12 | Row of the last accepted command |
| cmd_col | output | 9 | Burst start column of the last read or write |
| prech_all | output | 1 | The accepted precharge covered all banks |
| bank_open | output | 4 | Open flag per bank |
| illegal | output | 1 | Refused command |
| rd_oe | output | 1 | Output driver enable for this beat |
| wr_en | output | 1 | Array write strobe for this beat |

## Verification
A clock suspend and a command can land on the same edge. The bench presents a read while `cke` is low. It then places a full precharge on the void edge that follows. The expected result is that the strobe and code from the read stay as they were and every bank stays open. Only the next valid edge may close the banks. A second overlap is a refused command arriving while a write burst is in progress. In that case `illegal` must rise and the data mask must still drive `wr_en`, with the bank flags unchanged.

// File: rtl/sdram_fe_pkg.sv
// Package: shared command encoding for the SDRAM front end.
// Assumes: codes are stable and visible on the cmd_code port.
package sdram_fe_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: combinational command decoder.
// Maps the active-low strobes onto a command code.
// Assumes: any pattern without a defined meaning is a no-operation.
module sdram_cmd_decode
    import sdram_fe_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Decode the strobe pattern into a command
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_table.sv
// Module: per-bank open flag and row register.
// Gives combinational read-out of the selected bank.
// Assumes: the caller has already filtered illegal requests;
// a close request wins over an open on the same bank.
module sdram_bank_table #(
    parameter int NBANK = 4,
    parameter int ROW_W = 12,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              act_set,
    input  logic              pre_one,
    input  logic              pre_all,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row_in,
    output logic [NBANK-1:0]  open_o,
    output logic              sel_open,
    output logic [ROW_W-1:0]  sel_row
);
    logic [ROW_W-1:0] rows [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Update one bank's open flag and row on a valid edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_o[g] <= 1'b0;
                rows[g]   <= '0;
            end else if (en) begin
                if (pre_all || (pre_one && bank == BANK_W'(g))) begin
                    open_o[g] <= 1'b0;
                end else if (act_set && bank == BANK_W'(g)) begin
                    open_o[g] <= 1'b1;
                    rows[g]   <= row_in;
                end
            end
        end
    end

    // Present the state of the addressed bank
    always_comb begin
        sel_open = open_o[bank];
        sel_row  = rows[bank];
    end
endmodule

// File: rtl/sdram_dq_ctrl.sv
// Module: data-path direction and per-beat enables.
// Keeps the direction of the last column command and gates
// it with the data mask.
// Assumes: set_rd, set_wr and clr are mutually exclusive.
module sdram_dq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_rd,
    input  logic set_wr,
    input  logic clr,
    input  logic dqm,
    output logic rd_oe,
    output logic wr_en
);
    logic in_rd, in_wr;
    logic nxt_rd, nxt_wr;

    // Direction that applies after this edge
    always_comb begin
        nxt_rd = in_rd;
        nxt_wr = in_wr;
        if (set_rd) begin
            nxt_rd = 1'b1;
            nxt_wr = 1'b0;
        end else if (set_wr) begin
            nxt_rd = 1'b0;
            nxt_wr = 1'b1;
        end else if (clr) begin
            nxt_rd = 1'b0;
            nxt_wr = 1'b0;
        end
    end

    // Register direction and masked enables on valid edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rd <= 1'b0;
            in_wr <= 1'b0;
            rd_oe <= 1'b0;
            wr_en <= 1'b0;
        end else if (en) begin
            in_rd <= nxt_rd;
            in_wr <= nxt_wr;
            rd_oe <= nxt_rd & ~dqm;
            wr_en <= nxt_wr & ~dqm;
        end
    end
endmodule

// File: rtl/sdram_cmd_front.sv
// Module: top of the SDRAM command front end.
// It samples the command pins, filters illegal requests, tracks
// the banks and registers the decoded fields.
// Assumes: cke is sampled every edge; a low cke voids the next edge.
module sdram_cmd_front
    import sdram_fe_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 9,
    parameter int PRE_BIT = 10,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [BANK_W-1:0] bsel,
    input  logic              dqm,
    output logic              cmd_vld,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              prech_all,
    output logic [NBANK-1:0]  bank_open,
    output logic              illegal,
    output logic              rd_oe,
    output logic              wr_en
);
    cmd_e             cmd;
    logic             cke_q;
    logic             edge_ok;
    logic             sel_open;
    logic [ROW_W-1:0] sel_row;
    logic             acc_act, acc_rd, acc_wr, acc_pre, bad;
    logic             accepted;
    cmd_e             acc_code;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    // Remember cke to decide whether the next edge counts
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end
    assign edge_ok = cke_q;

    // Legality filter against the addressed bank
    always_comb begin
        acc_act  = (cmd == CMD_ACT) && !sel_open;
        acc_rd   = (cmd == CMD_RD)  &&  sel_open;
        acc_wr   = (cmd == CMD_WR)  &&  sel_open;
        acc_pre  = (cmd == CMD_PRE);
        bad      = ((cmd == CMD_RD || cmd == CMD_WR) && !sel_open) ||
                   ((cmd == CMD_ACT) && sel_open);
        accepted = acc_act | acc_rd | acc_wr | acc_pre;
        acc_code = accepted ? cmd : CMD_NOP;
    end

    sdram_bank_table #(.NBANK(NBANK), .ROW_W(ROW_W)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (edge_ok),
        .act_set (acc_act),
        .pre_one (acc_pre && !addr[PRE_BIT]),
        .pre_all (acc_pre &&  addr[PRE_BIT]),
        .bank    (bsel),
        .row_in  (addr),
        .open_o  (bank_open),
        .sel_open(sel_open),
        .sel_row (sel_row)
    );

    sdram_dq_ctrl u_dq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (edge_ok),
        .set_rd(acc_rd),
        .set_wr(acc_wr),
        .clr   (acc_pre),
        .dqm   (dqm),
        .rd_oe (rd_oe),
        .wr_en (wr_en)
    );

    // Register the decoded command fields on valid edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld   <= 1'b0;
            cmd_code  <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            prech_all <= 1'b0;
            illegal   <= 1'b0;
        end else if (edge_ok) begin
            cmd_vld   <= accepted;
            cmd_code  <= acc_code;
            illegal   <= bad;
            prech_all <= acc_pre && addr[PRE_BIT];
            if (accepted) cmd_bank <= bsel;
            if (acc_act) cmd_row <= addr;
            else if (acc_rd || acc_wr) cmd_row <= sel_row;
            if (acc_rd || acc_wr) cmd_col <= addr[COL_W-1:0];
        end
    end
endmodule

// File: rtl/sdram_cmd_front_chk.sv
// Module: property checker for sdram_cmd_front, attached by bind.
// Assumes: the same clock and synchronous reset as the design.
module sdram_cmd_front_chk #(
    parameter int NBANK = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              a10,
    input logic [BANK_W-1:0] bsel,
    input logic              cmd_vld,
    input logic              illegal,
    input logic [NBANK-1:0]  bank_open,
    input logic              rd_oe,
    input logic              wr_en
);
    logic cke_d;

    // Local copy of the previous edge's cke
    always_ff @(posedge clk) begin
        if (!rst_n) cke_d <= 1'b1;
        else        cke_d <= cke;
    end

    p_suspend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cke_d) |=> ($stable(bank_open) && $stable(cmd_vld) &&
                               $stable(rd_oe) && $stable(wr_en)));

    p_deselect_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cke_d && cs_n) |=> ($stable(bank_open) && !cmd_vld));

    p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cke_d && !cs_n && !ras_n && cas_n && we_n)
        |=> bank_open[$past(bsel)]);

    p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cke_d && !cs_n && !ras_n && cas_n && !we_n && a10)
        |=> (bank_open == '0));

    p_enable_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_oe && wr_en));

    p_illegal_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !cmd_vld);
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.NBANK(NBANK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (addr[PRE_BIT]),
    .bsel     (bsel),
    .cmd_vld  (cmd_vld),
    .illegal  (illegal),
    .bank_open(bank_open),
    .rd_oe    (rd_oe),
    .wr_en    (wr_en)
);

// File: tb/sdram_cmd_front_tb.sv
// Bench for sdram_cmd_front: a table walk followed by directed cases.
module sdram_cmd_front_tb;
    logic        clk = 1'b0;
    logic        rst_n, cke, cs_n, ras_n, cas_n, we_n, dqm;
    logic [11:0] addr;
    logic [1:0]  bsel;
    logic        cmd_vld, prech_all, illegal, rd_oe, wr_en;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [8:0]  cmd_col;
    logic [3:0]  bank_open;
    int          runs = 0;
    int          fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    sdram_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .bsel(bsel), .dqm(dqm),
        .cmd_vld(cmd_vld), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .prech_all(prech_all),
        .bank_open(bank_open), .illegal(illegal), .rd_oe(rd_oe), .wr_en(wr_en)
    );

    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                           WR = 4'b0100, PRE = 4'b0010, DES = 4'b1011;

    // {cke, cmd4, bsel2, addr12, dqm | vld, code3, open4, oe, wr, ill}
    localparam int NV = 13;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, ACT, 2'd0, 12'h123, 1'b0, 1'b1, 3'd1, 4'b0001, 1'b0, 1'b0, 1'b0},
        {1'b1, ACT, 2'd2, 12'hABC, 1'b0, 1'b1, 3'd1, 4'b0101, 1'b0, 1'b0, 1'b0},
        {1'b1, RD,  2'd0, 12'h005, 1'b0, 1'b1, 3'd2, 4'b0101, 1'b1, 1'b0, 1'b0},
        {1'b1, RD,  2'd0, 12'h006, 1'b1, 1'b1, 3'd2, 4'b0101, 1'b0, 1'b0, 1'b0},
        {1'b1, WR,  2'd2, 12'h007, 1'b0, 1'b1, 3'd3, 4'b0101, 1'b0, 1'b1, 1'b0},
        {1'b1, WR,  2'd2, 12'h008, 1'b1, 1'b1, 3'd3, 4'b0101, 1'b0, 1'b0, 1'b0},
        {1'b1, RD,  2'd1, 12'h009, 1'b0, 1'b0, 3'd0, 4'b0101, 1'b0, 1'b1, 1'b1},
        {1'b1, ACT, 2'd0, 12'h555, 1'b1, 1'b0, 3'd0, 4'b0101, 1'b0, 1'b0, 1'b1},
        {1'b1, PRE, 2'd2, 12'h000, 1'b0, 1'b1, 3'd4, 4'b0001, 1'b0, 1'b0, 1'b0},
        {1'b1, NOP, 2'd0, 12'h000, 1'b0, 1'b0, 3'd0, 4'b0001, 1'b0, 1'b0, 1'b0},
        {1'b1, DES, 2'd1, 12'h0FF, 1'b0, 1'b0, 3'd0, 4'b0001, 1'b0, 1'b0, 1'b0},
        {1'b1, ACT, 2'd3, 12'h7FF, 1'b0, 1'b1, 3'd1, 4'b1001, 1'b0, 1'b0, 1'b0},
        {1'b1, PRE, 2'd0, 12'h400, 1'b0, 1'b1, 3'd4, 4'b0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        runs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic k, input logic [3:0] c, input logic [1:0] b,
                         input logic [11:0] a, input logic m);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        bsel = b;
        addr = a;
        dqm = m;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, NOP, 2'd0, 12'h0, 1'b0);
        step();
        step();
        // R12: reset state
        chk("R12 open", 32'(bank_open), 32'h0);
        chk("R12 vld", 32'(cmd_vld), 32'h0);
        chk("R12 oe/wr", 32'({rd_oe, wr_en}), 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][30], VEC[i][29:26], VEC[i][25:24], VEC[i][23:12], VEC[i][11]);
            step();
            chk($sformatf("R1 vld step %0d", i), 32'(cmd_vld), 32'(VEC[i][10]));
            chk($sformatf("R1 code step %0d", i), 32'(cmd_code), 32'(VEC[i][9:7]));
            chk($sformatf("R7/R8 open step %0d", i), 32'(bank_open), 32'(VEC[i][6:3]));
            chk($sformatf("R9 rd_oe step %0d", i), 32'(rd_oe), 32'(VEC[i][2]));
            chk($sformatf("R10 wr_en step %0d", i), 32'(wr_en), 32'(VEC[i][1]));
            chk($sformatf("R11 illegal step %0d", i), 32'(illegal), 32'(VEC[i][0]));
            if (i == 12) chk("R6 prech_all", 32'(prech_all), 32'h1);
            if (i == 8)  chk("R7 prech_all low", 32'(prech_all), 32'h0);
        end

        // R4, R8: activate bank 1 and report its row
        drive(1'b1, ACT, 2'd1, 12'h9C3, 1'b0);
        step();
        chk("R4 row", 32'(cmd_row), 32'h9C3);
        chk("R8 bank", 32'(cmd_bank), 32'h1);
        chk("R8 open bit", 32'(bank_open), 32'h2);

        // R5: column from addr[8:0], row of the open bank
        drive(1'b1, RD, 2'd1, 12'hFA5, 1'b0);
        step();
        chk("R5 col", 32'(cmd_col), 32'h1A5);
        chk("R5 row", 32'(cmd_row), 32'h9C3);

        // R2: read while cke low; the next edge (a full precharge) is void
        drive(1'b0, RD, 2'd1, 12'h010, 1'b0);
        step();
        chk("R2 read taken", 32'(cmd_code), 32'h2);
        drive(1'b1, PRE, 2'd0, 12'h400, 1'b1);
        step();
        chk("R2 open held", 32'(bank_open), 32'h2);
        chk("R2 code held", 32'(cmd_code), 32'h2);
        chk("R2 vld held", 32'(cmd_vld), 32'h1);
        chk("R2 oe held", 32'(rd_oe), 32'h1);
        step();
        chk("R6 closed after valid edge", 32'(bank_open), 32'h0);

        // R12: reset clears an open bank and its row
        drive(1'b1, ACT, 2'd3, 12'h321, 1'b0);
        step();
        rst_n = 1'b0;
        drive(1'b1, NOP, 2'd0, 12'h0, 1'b0);
        step();
        rst_n = 1'b1;
        chk("R12 open cleared", 32'(bank_open), 32'h0);
        chk("R12 row cleared", 32'(cmd_row), 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule